// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block models the command interface of a x16 parallel NOR flash device as synchronous logic. Asynchronous chip-enable, write-enable and output-enable strobes, together with the address and data buses, pass through a two-stage synchronizer into the system clock domain. A bus write is the interval in which both the chip enable and the write enable are low. The address is taken when that interval opens and the data when it closes.

Writes are decoded as unlock-prefixed command sequences for word program, sector erase, block erase and chip erase. A complete sequence starts an internal busy phase whose length is a parameter in clock cycles. At the end of that phase the block updates a small internal word array. While the phase runs, reads return a status word in place of array data, and all further writes are dropped.

The array always has DEPTH = 2^MEM_AW words. Sector and block sizes are 2^SECT_AW and 2^BLK_AW words, scaled down from the 2K-word and 32K-word sizes of a real part.

Top module: `nor_cmd_decoder`

## Requirements
- R1: A bus write takes its address in the first cycle in which the synchronized CE# and WE# are both low. It takes its data from the last cycle before either strobe returns high. This holds whichever strobe falls last and whichever strobe rises first.
- R2: `dq_oe` is 1 only while the synchronized CE# and OE# are both low, and `dq_out` is 0 whenever `dq_oe` is 0.
- R3: Word program is the write sequence AAh@5555h, 55h@2AAAh, A0h@5555h, followed by a write carrying the target address and data. Command bytes are compared on data bits 7:0 only, and unlock addresses on the full address bus. After the busy phase, the word at addr[MEM_AW-1:0] reads back as its old value ANDed with the written data.
- R4: Sector erase is the sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address. After the busy phase, every word whose index shares the bits above bit SECT_AW-1 with the latched address reads FFFFh. All other words are unchanged.
- R5: Block erase is the same sequence with 50h in the last write. After the busy phase, it sets to FFFFh the aligned region of 2^BLK_AW words that holds the latched address.
- R6: Chip erase is the same sequence with 10h written at 5555h in the last write. It sets every word to FFFFh. The byte 10h written at any other address starts nothing.
- R7: A write that does not match the next expected step returns the decoder to idle and leaves the array unchanged. That write does not itself begin a new sequence.
- R8: Every write issued while the busy phase runs is ignored, including a complete program sequence.
- R9: A read during the busy phase returns a status word. Bit 7 is the complement of bit 7 of the data being programmed, or 0 during any erase. Bit 6 starts at 0 for each operation and inverts after each completed read. All other bits are 0.
- R10: Programming can only clear bits. A second program of a word leaves the AND of both data values.
- R11: The busy phase lasts T_PROG, T_SECT, T_BLK or T_CHIP cycles according to the operation. Reads return array data again once it ends.
- R12: After reset the decoder is idle and every word reads FFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Word address bus |
| dq_in | input | DATA_W | Data bus, write direction |
| dq_out | output | DATA_W | Data bus, read direction (0 when not driven) |
| dq_oe | output | 1 | High while the data bus is driven |

## Verification
The bench programs every word of a 64-word array with a computed pattern and reprograms one word to show that bits only clear. It then erases one sector and one block and compares the whole array against a bench model after each step.

- **Moving address and data.** One write moves its address after the strobes fall and its data just before they rise. A decoder that latched on the wrong edge would program the neighbouring word or store the early data.
- **Broken sequences.** A bad second unlock, an unknown final byte, and 10h at the wrong address each leave the array untouched. A decoder that accepted any of them would corrupt the array.
- **Writes during busy.** A full program sequence issued inside an erase must leave its target unchanged; a decoder that queued or decoded it would alter that word.
- **Status word.** Back-to-back status reads check the DQ7 polarity and the DQ6 alternation. A read between the program time and the erase time shows that each operation is timed by its own count.

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int MEM_AW  = 6,
  parameter int SECT_AW = 2,
  parameter int BLK_AW  = 4,
  parameter int T_PROG  = 30,
  parameter int T_SECT  = 60,
  parameter int T_BLK   = 80,
  parameter int T_CHIP  = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int CW    = $clog2(T_PROG + T_SECT + T_BLK + T_CHIP + 1);
  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(32'h5555);
  localparam logic [ADDR_W-1:0] KEY_B = ADDR_W'(32'h2AAA);

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PGM, S_E3, S_E4, S_E5} state_t;
  typedef enum logic [1:0] {O_PROG, O_SECT, O_BLK, O_CHIP} op_t;

  logic [2:0]        strb1, strb2;
  logic [ADDR_W-1:0] a1, a2, lat_a;
  logic [DATA_W-1:0] d1, d2, dat_q;
  logic              wr_q, rd_q;
  state_t            state;
  op_t               op;
  logic [MEM_AW-1:0] op_a;
  logic [DATA_W-1:0] op_d;
  logic              busy, tgl;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] status;

  // two-stage synchronizer for strobes and buses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb1 <= 3'b111; strb2 <= 3'b111;
      a1 <= '0; a2 <= '0; d1 <= '0; d2 <= '0;
    end else begin
      strb1 <= {ce_n, we_n, oe_n}; strb2 <= strb1;
      a1 <= addr; a2 <= a1; d1 <= dq_in; d2 <= d1;
    end
  end

  wire wr_act   = ~strb2[2] & ~strb2[1];
  wire rd_act   = ~strb2[2] & ~strb2[0];
  wire wr_start = wr_act & ~wr_q;
  wire wr_end   = ~wr_act & wr_q;
  wire rd_end   = ~rd_act & rd_q;
  wire [7:0] cmd = dat_q[7:0];
  wire at_a = (lat_a == KEY_A);
  wire at_b = (lat_a == KEY_B);
  wire done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0; rd_q <= 1'b0; lat_a <= '0; dat_q <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_start) lat_a <= a2;
      if (wr_act)   dat_q <= d2;
    end
  end

  function automatic logic in_region(input int idx, input logic [MEM_AW-1:0] base, input int aw);
    logic [MEM_AW-1:0] iv;
    iv = MEM_AW'(idx);
    return (iv >> aw) == (base >> aw);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; op <= O_PROG; op_a <= '0; op_d <= '0;
      busy <= 1'b0; tgl <= 1'b0; cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (busy) begin
      state <= S_IDLE;
      if (rd_end) tgl <= ~tgl;
      if (cnt != '0) cnt <= cnt - 1'b1;
      else begin
        busy <= 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
          case (op)
            O_PROG: if (MEM_AW'(i) == op_a) mem[i] <= mem[i] & op_d;
            O_SECT: if (in_region(i, op_a, SECT_AW)) mem[i] <= '1;
            O_BLK:  if (in_region(i, op_a, BLK_AW)) mem[i] <= '1;
            default: mem[i] <= '1;
          endcase
        end
      end
    end else if (wr_end) begin
      state <= S_IDLE;
      case (state)
        S_IDLE: if (at_a && cmd == 8'hAA) state <= S_U1;
        S_U1:   if (at_b && cmd == 8'h55) state <= S_U2;
        S_U2: begin
          if (at_a && cmd == 8'hA0) state <= S_PGM;
          if (at_a && cmd == 8'h80) state <= S_E3;
        end
        S_PGM: begin
          op <= O_PROG; op_a <= lat_a[MEM_AW-1:0]; op_d <= dat_q;
          busy <= 1'b1; tgl <= 1'b0; cnt <= CW'(T_PROG - 1);
        end
        S_E3: if (at_a && cmd == 8'hAA) state <= S_E4;
        S_E4: if (at_b && cmd == 8'h55) state <= S_E5;
        S_E5: begin
          op_a <= lat_a[MEM_AW-1:0];
          if (cmd == 8'h30) begin
            op <= O_SECT; busy <= 1'b1; tgl <= 1'b0; cnt <= CW'(T_SECT - 1);
          end else if (cmd == 8'h50) begin
            op <= O_BLK; busy <= 1'b1; tgl <= 1'b0; cnt <= CW'(T_BLK - 1);
          end else if (cmd == 8'h10 && at_a) begin
            op <= O_CHIP; busy <= 1'b1; tgl <= 1'b0; cnt <= CW'(T_CHIP - 1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    status    = '0;
    status[7] = (op == O_PROG) ? ~op_d[7] : 1'b0;
    status[6] = tgl;
  end

  assign dq_oe  = rd_act;
  assign dq_out = !rd_act ? '0 : (busy ? status : mem[a2[MEM_AW-1:0]]);

  wire [DATA_W-1:0] mem_at_op = mem[op_a];

  assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));
  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (state == S_IDLE));
  assert_busy_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && $stable(op) && $stable(op_a)));
  assert_only_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == O_PROG) |=> ((mem_at_op & ~$past(mem_at_op)) == '0));
  assert_chip_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == O_CHIP) |=> (mem[0] == '1 && mem[DEPTH-1] == '1));
  assert_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_end) |=> (tgl != $past(tgl)));
  assert_erase_dq7_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op != O_PROG && dq_oe) |-> !dq_out[7]);
endmodule

// File: tb/nor_cmd_decoder_bench.sv
module nor_cmd_decoder_bench;
  localparam int TP = 30, TS = 60, TB = 80, TC = 120;
  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1;
  logic [15:0] addr = '0, dq_in = '0;
  logic [15:0] dq_out;
  logic dq_oe;
  int checks = 0, errs = 0;
  bit finished = 0;
  logic [15:0] m [64];

  always #5 clk = ~clk;

  nor_cmd_decoder #(.ADDR_W(16), .DATA_W(16), .MEM_AW(6), .SECT_AW(2), .BLK_AW(4),
    .T_PROG(TP), .T_SECT(TS), .T_BLK(TB), .T_CHIP(TC)) u_nor_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); ce_n = 0; addr = a; dq_in = d;
    clks(1); we_n = 0; clks(3); we_n = 1; clks(1); ce_n = 1; clks(3);
  endtask

  task automatic wr_ce(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); we_n = 0; addr = a; dq_in = d;
    clks(1); ce_n = 0; clks(3); ce_n = 1; clks(1); we_n = 1; clks(3);
  endtask

  task automatic wr_skew(input logic [15:0] a, input logic [15:0] a_late,
                         input logic [15:0] d_early, input logic [15:0] d);
    @(negedge clk); ce_n = 0; addr = a; dq_in = d_early;
    clks(1); we_n = 0; clks(3); addr = a_late; clks(1); dq_in = d; clks(3);
    we_n = 1; clks(1); ce_n = 1; clks(3);
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v, output logic oe);
    @(negedge clk); ce_n = 0; oe_n = 0; addr = a;
    clks(4); v = dq_out; oe = dq_oe; oe_n = 1; ce_n = 1; clks(3);
  endtask

  task automatic prog(input logic [15:0] a, input logic [15:0] d);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0); wr(a, d);
  endtask

  task automatic erase(input logic [15:0] a, input logic [15:0] c);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0080);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(a, c);
  endtask

  task automatic verify_all(input string tag);
    logic [15:0] v; logic oe;
    for (int i = 0; i < 64; i++) begin
      rd(16'(i), v, oe);
      chk($sformatf("%s word %0d", tag, i), v, m[i]);
    end
  endtask

  function automatic logic [15:0] st(input logic b7, input logic b6);
    logic [15:0] s; s = '0; s[7] = b7; s[6] = b6; return s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v; logic oe;
    for (int i = 0; i < 64; i++) m[i] = 16'hFFFF;
    clks(3); rst_n = 1; clks(2);

    // R12, R2: reset state and bus gating
    chk("R2 idle dq_oe", {15'b0, dq_oe}, 16'h0);
    chk("R2 idle dq_out", dq_out, 16'h0);
    ce_n = 1; oe_n = 0; clks(4);
    chk("R2 ce high oe low", {15'b0, dq_oe}, 16'h0);
    chk("R2 ce high data", dq_out, 16'h0);
    ce_n = 0; oe_n = 1; clks(4);
    chk("R2 oe high", {15'b0, dq_oe}, 16'h0);
    ce_n = 1; clks(3);
    rd(16'h0000, v, oe);
    chk("R2 read drives", {15'b0, oe}, 16'h1);
    chk("R12 reset ones", v, 16'hFFFF);

    // R3, R9, R11: first program with status reads
    prog(16'h0003, 16'h1234);
    rd(16'h0003, v, oe);
    chk("R9 prog status 1", v, st(1'b1, 1'b0));
    rd(16'h0003, v, oe);
    chk("R9 prog status 2", v, st(1'b1, 1'b1));
    clks(TP);
    m[3] = 16'h1234;
    rd(16'h0003, v, oe);
    chk("R11 data after program", v, 16'h1234);
    prog(16'h0004, 16'h00F0);
    rd(16'h0004, v, oe);
    chk("R9 prog status bit7 clear", v, st(1'b0, 1'b0));
    clks(TP);
    m[4] = 16'h00F0;

    // R3 sweep over all words
    for (int i = 0; i < 64; i++) begin
      if (i != 3 && i != 4) begin
        logic [15:0] p;
        p = 16'((i * 16'h1F3B) ^ 16'hA55A);
        prog(16'(i), p); clks(TP + 5);
        m[i] = m[i] & p;
      end
    end
    verify_all("R3 sweep");

    // R10: reprogram clears only
    prog(16'h0005, 16'hF0F0); clks(TP + 5);
    m[5] = m[5] & 16'hF0F0;
    rd(16'h0005, v, oe);
    chk("R10 and of both", v, m[5]);

    // R4: sector erase, R9 erase status, R11 longer busy
    erase(16'h0009, 16'h0030);
    rd(16'h0009, v, oe);
    chk("R9 erase status", v, st(1'b0, 1'b0));
    clks(TP);
    rd(16'h0020, v, oe);
    chk("R11 erase still busy", v, st(1'b0, 1'b1));
    clks(TS);
    for (int i = 8; i < 12; i++) m[i] = 16'hFFFF;
    verify_all("R4 sector");

    // R5: block erase
    erase(16'h0023, 16'h0050); clks(TB + 5);
    for (int i = 32; i < 48; i++) m[i] = 16'hFFFF;
    verify_all("R5 block");

    // R7: broken sequences
    wr(16'h5555, 16'h00AA); wr(16'h1234, 16'h0055); wr(16'h5555, 16'h00A0);
    wr(16'h0007, 16'h0000); clks(TP + 5);
    rd(16'h0007, v, oe);
    chk("R7 bad unlock", v, m[7]);
    erase(16'h0011, 16'h0020); clks(TC + 5);
    rd(16'h0011, v, oe);
    chk("R7 bad erase cmd", v, m[17]);
    erase(16'h0012, 16'h0010); clks(TC + 5);
    verify_all("R6 chip cmd wrong addr");
    prog(16'h0006, 16'h0000); clks(TP + 5);
    m[6] = 16'h0000;
    rd(16'h0006, v, oe);
    chk("R7 recovers after break", v, 16'h0000);

    // R8: program issued during a sector erase is ignored
    erase(16'h0001, 16'h0030);
    prog(16'h003C, 16'h0000);
    clks(TS + 5);
    for (int i = 0; i < 4; i++) m[i] = 16'hFFFF;
    rd(16'h003C, v, oe);
    chk("R8 write during busy", v, m[60]);
    rd(16'h0002, v, oe);
    chk("R8 erase still applied", v, 16'hFFFF);

    // R1: moving address and data, CE-controlled write
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0);
    wr_skew(16'h0028, 16'h0029, 16'h0000, 16'h1234); clks(TP + 5);
    m[40] = 16'h1234;
    rd(16'h0028, v, oe);
    chk("R1 address at start data at end", v, 16'h1234);
    rd(16'h0029, v, oe);
    chk("R1 late address unused", v, m[41]);
    wr_ce(16'h5555, 16'h00AA); wr_ce(16'h2AAA, 16'h0055); wr_ce(16'h5555, 16'h00A0);
    wr_ce(16'h0021, 16'h4321); clks(TP + 5);
    m[33] = 16'h4321;
    rd(16'h0021, v, oe);
    chk("R1 ce-controlled write", v, 16'h4321);

    // R6: chip erase
    erase(16'h5555, 16'h0010);
    clks(TB);
    rd(16'h0000, v, oe);
    chk("R11 chip still busy", v, st(1'b0, 1'b0));
    clks(TC);
    for (int i = 0; i < 64; i++) m[i] = 16'hFFFF;
    verify_all("R6 chip");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule